// File: doc/BRIEF.md
# ADC Conversion Sequencer (Externally Clocked Mode)

This block is the host-side controller for a serial ADC that runs in its externally clocked mode. The host supplies every SCLK edge, and the converter has no internal clock or scan engine. A one-cycle start request carries a channel number, a temperature-read flag and a reference wake-up flag. For each request the sequencer lowers chip select and sends a one-byte conversion command. It then supplies the SCLK edges that move the result out of the converter, and returns the result on a parallel port with a one-cycle valid strobe.

There are three variants of the basic command. A wake-up request holds chip select high for a timed gap after the command byte, so that the converter's reference can settle before the read. A temperature request clocks 24 zero bytes and keeps only the final 16 bits. A plain request that arrives during the first read byte of a plain conversion is sent as the next command inside the current read. This gives back-to-back conversions at 16 SCLK cycles each, with no chip-select gap between them.

The serial interface runs in SPI mode 0. SCLK idles low, DIN changes after falling edges, and DOUT is sampled on rising edges. One SCLK period is `2*SCLK_HALF` system clocks. All time limits are derived from `CLK_HZ`.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is applied, and after it is released with no request, cs_n_o is 1, sclk_o is 0, busy_o is 0 and both valid strobes are 0.
- R2: A command byte is sent MSB first as {1, chan[3:0], 0, 0, temp}. DIN changes only while SCLK is low, and SCLK stays low whenever cs_n_o is high.
- R3: A plain conversion holds cs_n_o low for exactly 8 + 16 SCLK cycles (96 system clocks with SCLK_HALF=2). DIN is 0 throughout the 16 read cycles. cs_n_o then returns high.
- R4: The first read bit is bit 15 of a 16-bit word. sample_o carries bits [11:2] of that word, with a one-cycle sample_valid_o pulse when the read ends. Bits [15:12] and [1:0] have no effect.
- R5: Chaining. A plain request that arrives during the first 8 read cycles of a plain conversion is sent as the command in read cycles 9 to 16, and its own 16 read cycles follow with no cs_n_o high gap.
- R6: With wake_i set, cs_n_o goes high after the command byte for exactly 65 µs of system clocks (3250 at 50 MHz). SCLK stays low during the gap, and the 16 read cycles follow.
- R7: Every chip-select-high gap inserted between the command byte and the read lasts less than 100 µs.
- R8: A temperature request clocks 192 zero-DIN read cycles. temp_o equals the final 16 bits received, and temp_valid_o pulses once; all earlier read bits have no effect. One LSB of the word is 0.125 °C.
- R9: busy_o is high from the cycle after a request is accepted until the last read cycle ends: 96 cycles for a plain conversion and 160 for a chained pair.
- R10: A start request is ignored in each of these cases: while a command byte is being sent, during a gap, during a temperature read, during the second read byte, or while a chained request is already held. An ignored request produces no command byte and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 4 | Channel number for the request |
| temp_i | input | 1 | Request a temperature read |
| wake_i | input | 1 | Insert the reference wake-up gap |
| busy_o | output | 1 | Sequence in progress or request held |
| cs_n_o | output | 1 | Chip select to the ADC, active low |
| sclk_o | output | 1 | Serial clock to the ADC |
| din_o | output | 1 | Serial data to the ADC |
| dout_i | input | 1 | Serial data from the ADC |
| sample_o | output | 10 | Last conversion result |
| sample_valid_o | output | 1 | One-cycle strobe for sample_o |
| temp_o | output | 16 | Last temperature word |
| temp_valid_o | output | 1 | One-cycle strobe for temp_o |

## Verification
The embedded assertions check the pin-level rules on every cycle:
- SCLK is quiet while chip select is high, and DIN is stable while SCLK is high.
- Chip select low implies busy, and the two result strobes never coincide.
- Each strobe follows a read cycle.
- The wake-up gap counter stays below the 100 µs bound.

Only the bench's scenarios can show the byte contents and counts. These include the command encoding, the 24-cycle, 40-cycle and 200-cycle chip-select windows, and the exact 3250-cycle gap. They also include the correct choice of bits for the sample and the temperature word, chaining without a gap, and the fact that requests in the wrong window produce no traffic.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int CH_W  = 4;
  localparam int CMD_W = 8;
  localparam int RD_W  = 16;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMD  = 2'd1,
    S_GAP  = 2'd2,
    S_READ = 2'd3
  } seq_state_e;

  // Conversion command byte: start bit, channel, two zero bits, temperature flag.
  function automatic logic [CMD_W-1:0] mk_cmd(input logic [CH_W-1:0] ch, input logic temp);
    return {1'b1, ch, 2'b00, temp};
  endfunction
endpackage

// File: rtl/adcseq_sclk_gen.sv
module adcseq_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic bit_end_o
);
  localparam int PH_N = 2 * HALF;
  localparam int PH_W = (PH_N > 2) ? $clog2(PH_N) : 1;

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run_i)                          ph_d = '0;
    else if (ph_q == PH_W'(PH_N - 1))    ph_d = '0;
    else                                 ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // Rising SCLK edge coincides with the clock edge leaving phase HALF-1.
  assign rise_o    = run_i && (ph_q == PH_W'(HALF - 1));
  assign bit_end_o = run_i && (ph_q == PH_W'(PH_N - 1));
  assign sclk_o    = run_i && (ph_q >= PH_W'(HALF));
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
  parameter int TX_W = 8,
  parameter int RX_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [TX_W-1:0] load_byte_i,
  input  logic            shift_i,
  input  logic            sample_i,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic [RX_W-1:0] rx_o
);
  logic [TX_W-1:0] tx_q, tx_d;
  logic [RX_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)       tx_d = load_byte_i;
    else if (shift_i) tx_d = {tx_q[TX_W-2:0], 1'b0};
    rx_d = rx_q;
    if (sample_i)     rx_d = {rx_q[RX_W-2:0], sdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign sdo_o = tx_q[TX_W-1];
  assign rx_o  = rx_q;
endmodule

// File: rtl/adcseq_gap_timer.sv
module adcseq_gap_timer #(
  parameter int WAIT_CYC  = 3250,
  parameter int LIMIT_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(LIMIT_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) cnt_d = cnt_q + 1'b1;
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(WAIT_CYC - 1));

  AST_GAP_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < CNT_W'(LIMIT_CYC)));  // R7
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer import adcseq_pkg::*; #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SCLK_HALF  = 2,
  parameter int WAKE_US    = 65,
  parameter int GAP_MAX_US = 100,
  parameter int TEMP_BYTES = 24,
  parameter int SMP_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             temp_i,
  input  logic             wake_i,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             din_o,
  input  logic             dout_i,
  output logic [SMP_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic [RD_W-1:0]  temp_o,
  output logic             temp_valid_o
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int WAKE_CYC   = CYC_PER_US * WAKE_US;
  localparam int LIMIT_CYC  = CYC_PER_US * GAP_MAX_US;
  localparam int TEMP_BITS  = TEMP_BYTES * 8;
  localparam int CNT_W      = $clog2(TEMP_BITS);
  localparam int HALF_RD    = RD_W / 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             cur_temp_q, cur_temp_d, cur_wake_q, cur_wake_d;
  logic             chain_q, chain_d;
  logic             pend_v_q, pend_v_d, pend_temp_q, pend_temp_d, pend_wake_q, pend_wake_d;
  logic [CH_W-1:0]  pend_ch_q, pend_ch_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic             smp_v_q, smp_v_d;
  logic [RD_W-1:0]  tmp_q, tmp_d;
  logic             tmp_v_q, tmp_v_d;

  logic             run, rise, bit_end, gap_run, gap_done;
  logic             load;
  logic [CMD_W-1:0] load_byte;
  logic [RD_W-1:0]  rx;
  logic             accept_pend, chain_ok;
  logic [CNT_W-1:0] last_bit;

  assign run     = (state_q == S_CMD) || (state_q == S_READ);
  assign gap_run = (state_q == S_GAP);

  adcseq_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
    .clk(clk), .rst_n(rst_int_n), .run_i(run),
    .sclk_o(sclk_o), .rise_o(rise), .bit_end_o(bit_end));

  adcseq_shifter #(.TX_W(CMD_W), .RX_W(RD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .load_byte_i(load_byte),
    .shift_i(bit_end), .sample_i(rise), .sdi_i(dout_i),
    .sdo_o(din_o), .rx_o(rx));

  adcseq_gap_timer #(.WAIT_CYC(WAKE_CYC), .LIMIT_CYC(LIMIT_CYC)) u_gap (
    .clk(clk), .rst_n(rst_int_n), .run_i(gap_run), .done_o(gap_done));

  assign last_bit    = cur_temp_q ? CNT_W'(TEMP_BITS - 1) : CNT_W'(RD_W - 1);
  assign accept_pend = start_i && (state_q == S_READ) && !cur_temp_q && !pend_v_q &&
                       (bit_q < CNT_W'(HALF_RD));
  assign chain_ok    = pend_v_q && !pend_temp_q && !pend_wake_q && !cur_temp_q &&
                       (bit_q == CNT_W'(HALF_RD - 1));

  always_comb begin
    state_d     = state_q;
    bit_d       = bit_q;
    cur_temp_d  = cur_temp_q;
    cur_wake_d  = cur_wake_q;
    chain_d     = chain_q;
    pend_v_d    = pend_v_q;
    pend_ch_d   = pend_ch_q;
    pend_temp_d = pend_temp_q;
    pend_wake_d = pend_wake_q;
    smp_d       = smp_q;
    smp_v_d     = 1'b0;
    tmp_d       = tmp_q;
    tmp_v_d     = 1'b0;
    load        = 1'b0;
    load_byte   = '0;

    if (accept_pend) begin
      pend_v_d    = 1'b1;
      pend_ch_d   = chan_i;
      pend_temp_d = temp_i;
      pend_wake_d = wake_i;
    end

    unique case (state_q)
      S_IDLE: begin
        if (pend_v_q) begin
          state_d    = S_CMD;
          bit_d      = '0;
          load       = 1'b1;
          load_byte  = mk_cmd(pend_ch_q, pend_temp_q);
          cur_temp_d = pend_temp_q;
          cur_wake_d = pend_wake_q;
          chain_d    = 1'b0;
          pend_v_d   = 1'b0;
        end else if (start_i) begin
          state_d    = S_CMD;
          bit_d      = '0;
          load       = 1'b1;
          load_byte  = mk_cmd(chan_i, temp_i);
          cur_temp_d = temp_i;
          cur_wake_d = wake_i;
          chain_d    = 1'b0;
        end
      end
      S_CMD: begin
        if (bit_end) begin
          if (bit_q == CNT_W'(CMD_W - 1)) begin
            bit_d   = '0;
            state_d = cur_wake_q ? S_GAP : S_READ;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      S_GAP: begin
        if (gap_done) state_d = S_READ;
      end
      S_READ: begin
        if (bit_end) begin
          if (bit_q == last_bit) begin
            bit_d = '0;
            if (cur_temp_q) begin
              tmp_d   = rx;
              tmp_v_d = 1'b1;
            end else begin
              smp_d   = rx[SMP_W+1:2];
              smp_v_d = 1'b1;
            end
            if (chain_q) begin
              state_d    = S_READ;
              cur_temp_d = 1'b0;
              cur_wake_d = 1'b0;
              chain_d    = 1'b0;
            end else begin
              state_d = S_IDLE;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            if (chain_ok) begin
              load      = 1'b1;
              load_byte = mk_cmd(pend_ch_q, 1'b0);
              chain_d   = 1'b1;
              pend_v_d  = 1'b0;
            end
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= S_IDLE;
      bit_q       <= '0;
      cur_temp_q  <= 1'b0;
      cur_wake_q  <= 1'b0;
      chain_q     <= 1'b0;
      pend_v_q    <= 1'b0;
      pend_ch_q   <= '0;
      pend_temp_q <= 1'b0;
      pend_wake_q <= 1'b0;
      smp_q       <= '0;
      smp_v_q     <= 1'b0;
      tmp_q       <= '0;
      tmp_v_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      bit_q       <= bit_d;
      cur_temp_q  <= cur_temp_d;
      cur_wake_q  <= cur_wake_d;
      chain_q     <= chain_d;
      pend_v_q    <= pend_v_d;
      pend_ch_q   <= pend_ch_d;
      pend_temp_q <= pend_temp_d;
      pend_wake_q <= pend_wake_d;
      smp_q       <= smp_d;
      smp_v_q     <= smp_v_d;
      tmp_q       <= tmp_d;
      tmp_v_q     <= tmp_v_d;
    end
  end

  assign cs_n_o         = !run;
  assign busy_o         = (state_q != S_IDLE) || pend_v_q;
  assign sample_o       = smp_q;
  assign sample_valid_o = smp_v_q;
  assign temp_o         = tmp_q;
  assign temp_valid_o   = tmp_v_q;

  AST_SCLK_QUIET_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n_o |-> !sclk_o);  // R2
  AST_DIN_HOLD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    sclk_o |-> $stable(din_o));  // R2
  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cs_n_o |-> busy_o);  // R9
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(sample_valid_o && temp_valid_o));  // R8
  AST_STROBE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample_valid_o || temp_valid_o) |-> $past(state_q == S_READ));  // R4
endmodule

// File: tb/adc_conv_sequencer_tb.sv
module adc_conv_sequencer_tb;
  localparam int WAKE_CYC  = 3250;
  localparam int LIMIT_CYC = 5000;
  localparam logic [15:0] TEMP_WORD = 16'h0C8A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  chan_i = '0;
  logic        temp_i = 1'b0;
  logic        wake_i = 1'b0;
  logic        busy_o, cs_n_o, sclk_o, din_o;
  logic        dout_i = 1'b0;
  logic [9:0]  sample_o;
  logic        sample_valid_o;
  logic [15:0] temp_o;
  logic        temp_valid_o;

  always #10 clk = ~clk;

  adc_conv_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .temp_i(temp_i),
    .wake_i(wake_i), .busy_o(busy_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o),
    .dout_i(dout_i), .sample_o(sample_o), .sample_valid_o(sample_valid_o),
    .temp_o(temp_o), .temp_valid_o(temp_valid_o));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [9:0] f_sample(input logic [3:0] ch);
    return {ch, ~ch, 2'b01};
  endfunction

  // Scoreboard queues
  logic [7:0]  cmd_q[$];
  logic [9:0]  smp_q[$];
  logic [15:0] tmp_q[$];

  // ADC model
  int          m_phase = 0;
  int          m_cnt = 0;
  int          m_len = 16;
  int          cmd_seen = 0;
  logic        m_temp = 1'b0;
  logic [7:0]  m_cmd = '0;
  logic [7:0]  m_next = '0;
  logic [15:0] m_word = '0;

  task automatic m_decode(input logic [7:0] c);
    cmd_seen++;
    if (cmd_q.size() == 0) begin
      chk("R10 unexpected command byte", {24'd0, c}, 32'd0);
    end else begin
      chk("R2 command byte", {24'd0, c}, {24'd0, cmd_q.pop_front()});
    end
    m_temp = c[0];
    m_len  = c[0] ? 192 : 16;
    m_word = {4'b0000, f_sample(c[6:3]), 2'b11};
    m_cnt  = 0;
    m_next = '0;
    m_phase = 1;
  endtask

  always @(posedge sclk_o) begin
    if (!cs_n_o) begin
      if (m_phase == 0) begin
        m_cmd = {m_cmd[6:0], din_o};
        m_cnt++;
        if (m_cnt == 8) m_decode(m_cmd);
      end else begin
        if (!m_temp && m_cnt >= 8) m_next = {m_next[6:0], din_o};
        else chk("R3 DIN zero during read", {31'd0, din_o}, 32'd0);
        m_cnt++;
        if (m_cnt == m_len) begin
          if (!m_temp && m_next[7]) m_decode(m_next);
          else begin
            if (!m_temp) chk("R3 DIN zero in second read byte", {24'd0, m_next}, 32'd0);
            m_phase = 0;
            m_cnt = 0;
          end
        end
      end
    end
  end

  always @(negedge sclk_o) begin
    if (m_phase == 1) begin
      if (m_temp) dout_i = (m_cnt < 176) ? 1'b1 : TEMP_WORD[191 - m_cnt];
      else        dout_i = m_word[15 - m_cnt];
    end else begin
      dout_i = 1'b0;
    end
  end

  // Window and strobe monitor
  logic cs_prev = 1'b1, sclk_prev = 1'b0, busy_prev = 1'b0;
  int   rises_win = 0, last_rises = 0, hi_run = 0, last_hi = 0, busy_run = 0, last_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n_o && sclk_o && !sclk_prev) rises_win++;
      if (!cs_prev && cs_n_o) begin
        last_rises = rises_win;
        rises_win = 0;
      end
      if (cs_n_o) hi_run++;
      else begin
        if (cs_prev) last_hi = hi_run;
        hi_run = 0;
      end
      if (busy_o) busy_run++;
      else begin
        if (busy_prev) last_busy = busy_run;
        busy_run = 0;
      end
      if (sample_valid_o) begin
        if (smp_q.size() == 0) chk("R4 unexpected sample strobe", 32'd1, 32'd0);
        else chk("R4 sample bits [11:2]", {22'd0, sample_o}, {22'd0, smp_q.pop_front()});
      end
      if (temp_valid_o) begin
        if (tmp_q.size() == 0) chk("R8 unexpected temp strobe", 32'd1, 32'd0);
        else chk("R8 temperature word", {16'd0, temp_o}, {16'd0, tmp_q.pop_front()});
      end
    end
    cs_prev = cs_n_o;
    sclk_prev = sclk_o;
    busy_prev = busy_o;
  end

  task automatic do_start(input logic [3:0] ch, input logic t, input logic w, input bit expect_accept);
    @(negedge clk);
    start_i = 1'b1; chan_i = ch; temp_i = t; wake_i = w;
    if (expect_accept) begin
      cmd_q.push_back({1'b1, ch, 2'b00, t});
      if (t) tmp_q.push_back(TEMP_WORD);
      else   smp_q.push_back(f_sample(ch));
    end
    @(negedge clk);
    start_i = 1'b0; temp_i = 1'b0; wake_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  int seen0;

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 cs_n in reset", {31'd0, cs_n_o}, 32'd1);
    chk("R1 sclk in reset", {31'd0, sclk_o}, 32'd0);
    chk("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    chk("R1 strobes in reset", {30'd0, sample_valid_o, temp_valid_o}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle after reset", {29'd0, cs_n_o, sclk_o, busy_o}, 32'd4);

    // R3/R4/R9: plain conversion
    do_start(4'd3, 1'b0, 1'b0, 1'b1);
    chk("R9 busy after accept", {31'd0, busy_o}, 32'd1);
    wait_idle();
    chk("R3 SCLK cycles per CS window", last_rises, 24);
    chk("R9 busy length plain", last_busy, 96);

    do_start(4'd12, 1'b0, 1'b0, 1'b1);
    wait_idle();
    do_start(4'd0, 1'b0, 1'b0, 1'b1);
    wait_idle();
    chk("R4 queue drained", smp_q.size(), 0);

    // R5: chained pair
    do_start(4'd7, 1'b0, 1'b0, 1'b1);
    wait (m_phase == 1 && m_cnt == 3);
    do_start(4'd9, 1'b0, 1'b0, 1'b1);
    wait_idle();
    chk("R5 one CS window for chained pair", last_rises, 40);
    chk("R5 busy length chained", last_busy, 160);

    // R10: second read byte window ignores a request
    seen0 = cmd_seen;
    do_start(4'd2, 1'b0, 1'b0, 1'b1);
    wait (m_phase == 1 && m_cnt == 10);
    do_start(4'd6, 1'b0, 1'b0, 1'b0);
    wait_idle();
    repeat (100) @(negedge clk);
    chk("R10 no command from late request", cmd_seen - seen0, 1);

    // R6/R7: wake-up gap
    do_start(4'd5, 1'b0, 1'b1, 1'b1);
    wait_idle();
    chk("R6 gap length", last_hi, WAKE_CYC);
    chk("R7 gap under limit", {31'd0, (last_hi < LIMIT_CYC)}, 32'd1);
    chk("R6 read cycles after gap", last_rises, 16);

    // R8/R10: temperature read, request during it ignored
    seen0 = cmd_seen;
    do_start(4'd0, 1'b1, 1'b0, 1'b1);
    wait (m_phase == 1 && m_cnt == 60);
    do_start(4'd2, 1'b0, 1'b0, 1'b0);
    wait_idle();
    repeat (100) @(negedge clk);
    chk("R8 temp read SCLK cycles", last_rises, 200);
    chk("R10 no command during temp read", cmd_seen - seen0, 1);

    // R6/R8: temperature read with wake-up gap
    do_start(4'd1, 1'b1, 1'b1, 1'b1);
    wait_idle();
    chk("R6 gap before temp read", last_hi, WAKE_CYC);
    chk("R8 read cycles after gap", last_rises, 192);

    // R10: request during command byte ignored
    seen0 = cmd_seen;
    do_start(4'd1, 1'b0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    do_start(4'd6, 1'b0, 1'b0, 1'b0);
    wait_idle();
    repeat (100) @(negedge clk);
    chk("R10 no command from request in command byte", cmd_seen - seen0, 1);

    chk("R4 all samples seen", smp_q.size(), 0);
    chk("R8 all temp words seen", tmp_q.size(), 0);
    chk("R2 all commands seen", cmd_q.size(), 0);
    report();
  end
endmodule